// File: doc/BRIEF.md
# Fixed-Point Complex Butterfly with Shared Multipliers

This block computes one radix-2 butterfly on complex samples whose real and imaginary parts are 16-bit signed fractions with 15 fraction bits. It takes an upper operand `u`, a lower operand `t` and a twiddle factor `w` of unit magnitude. It returns the pair `u + w*t` (upper result) and `u - w*t` (lower result). The block sits inside a larger transform engine. That engine owns the sample memory, the address sequencing and the twiddle source, and it presents one butterfly at a time.

The complex product `w*t` needs four real products. Only two real multipliers are built, and each is used on two consecutive cycles. On the cycle an operand set is accepted, the multipliers form the two products for the real part (`t_re*w_re` and `t_im*w_im`). On the next cycle they form the two products for the imaginary part (`t_re*w_im` and `t_im*w_re`) from captured copies of the operands.

A two-state machine runs the sequence. In state `ST_IDLE` the block is ready and the multipliers take their operands from the input ports. The ACCEPT transition (`in_valid` high while in `ST_IDLE`) moves it to `ST_SECOND`. In that state the multipliers take their operands from the captured registers. The FINISH transition (unconditional) returns it to `ST_IDLE` and loads the output registers.

A unity flag skips the multiply for stages whose twiddle is exactly one, because that value cannot be represented as a 15-bit fraction. A scale flag halves both results so that values cannot grow from stage to stage. Every result is clipped to the signed 16-bit range.

Top module: `q15_butterfly`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `in_ready` is 1 and all four result ports are 0 until the first result is delivered.
- R2: An operand set is accepted on a rising edge where `in_valid` and `in_ready` are both 1. On the cycle after an acceptance, `in_ready` is 0, and any operands offered during that cycle are ignored. `in_ready` then returns to 1, so at most one butterfly is accepted every second cycle.
- R3: If an operand set is accepted at rising edge k, `out_valid` is 1 and the results are present from edge k+1 until edge k+2. `out_valid` is 0 in every cycle that is not such a delivery cycle.
- R4: When `in_unity` is 0, the product is P = rnd(t_re*w_re) - rnd(t_im*w_im) for the real part and Q = rnd(t_re*w_im) + rnd(t_im*w_re) for the imaginary part. Here rnd(x) = floor((x + 16384) / 32768), which rounds the full product to nearest, with halves rounded up.
- R5: `top_re = u_re + P`, `top_im = u_im + Q`, `bot_re = u_re - P` and `bot_im = u_im - Q`. These are formed at full width before any scaling or clipping.
- R6: When `in_unity` is 1, P = `t_re` and Q = `t_im`, and `w_re` and `w_im` have no effect on the results.
- R7: When `in_scale` is 1, each full-width sum s is replaced by floor((s + 1) / 2) before clipping. When `in_scale` is 0, s is used unchanged.
- R8: Each result is clipped to the range -32768 to 32767. A value above the range gives 32767 and a value below it gives -32768.
- R9: The four result ports keep their last value in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operand set is offered |
| in_ready | output | 1 | The block can accept an operand set this cycle |
| in_unity | input | 1 | The twiddle is exactly one; skip the multiply |
| in_scale | input | 1 | Halve both results with rounding |
| u_re | input | 16 | Upper operand, real part (signed Q15) |
| u_im | input | 16 | Upper operand, imaginary part (signed Q15) |
| t_re | input | 16 | Lower operand, real part (signed Q15) |
| t_im | input | 16 | Lower operand, imaginary part (signed Q15) |
| w_re | input | 16 | Twiddle, real part (signed Q15) |
| w_im | input | 16 | Twiddle, imaginary part (signed Q15) |
| out_valid | output | 1 | The results are new this cycle |
| top_re | output | 16 | Real part of u + w*t |
| top_im | output | 16 | Imaginary part of u + w*t |
| bot_re | output | 16 | Real part of u - w*t |
| bot_im | output | 16 | Imaginary part of u - w*t |

## Verification
The main function is tried with several kinds of twiddle:
- A twiddle close to one and a twiddle of a quarter turn check that the real and imaginary product pairs are routed to the right multiplier phase and combined with the right signs.
- An eighth-turn twiddle and a long run of random operands check the rounding of each partial product.
- A twiddle of -32768 with a lower operand of -32768 produces a product of exactly +1.0, which only fits because the product is kept wider than 16 bits.

Unity operands are offered with nonzero twiddle values, so any leak of the twiddle into the bypass path changes the result. Scaled and unscaled runs with odd sums tell the rounding of the halving apart from plain truncation. Operands are held valid on every cycle, so a block that does not ignore the operands offered in its busy cycle shows up as a wrong result count.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // ST_IDLE   : ready; the multipliers take real-part operands from the ports
    // ST_SECOND : busy; the multipliers take imaginary-part operands from registers
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } bfly_state_e;

    localparam int NUM_MULT = 2;

endpackage

// File: rtl/q15_rmul.sv
// Signed fractional multiplier: full product rounded to nearest, then scaled
// back to the fraction format. The result is one bit wider than the operands,
// so (-1.0) * (-1.0) = +1.0 can be represented.
module q15_rmul #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W:0]   y
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (W - 2);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_rnd;

    always_comb begin
        prod     = a * b;
        prod_rnd = prod + HALF_LSB;
        y        = prod_rnd[PW-1:W-1];
    end
endmodule

// File: rtl/bfly_lane.sv
// One component lane: sum and difference against the product term, optional
// rounded halving, then clipping to the W-bit signed range.
module bfly_lane #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] u,
    input  logic signed [W+1:0] v,
    input  logic                scale,
    output logic signed [W-1:0] sum,
    output logic signed [W-1:0] dif
);
    localparam int XW = W + 3;
    localparam logic signed [XW-1:0] MAXV = XW'((1 <<< (W - 1)) - 1);
    localparam logic signed [XW-1:0] MINV = -(XW'(1) <<< (W - 1));

    function automatic logic signed [W-1:0] finish(input logic signed [XW-1:0] s,
                                                   input logic sc);
        logic signed [XW-1:0] h;
        h = sc ? ((s + XW'(1)) >>> 1) : s;
        if (h > MAXV)
            return MAXV[W-1:0];
        else if (h < MINV)
            return MINV[W-1:0];
        else
            return h[W-1:0];
    endfunction

    logic signed [XW-1:0] ux;
    logic signed [XW-1:0] vx;

    always_comb begin
        ux  = {{3{u[W-1]}}, u};
        vx  = {v[W+1], v};
        sum = finish(ux + vx, scale);
        dif = finish(ux - vx, scale);
    end
endmodule

// File: rtl/q15_butterfly.sv
module q15_butterfly
    import bfly_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_unity,
    input  logic                in_scale,
    input  logic signed [W-1:0] u_re,
    input  logic signed [W-1:0] u_im,
    input  logic signed [W-1:0] t_re,
    input  logic signed [W-1:0] t_im,
    input  logic signed [W-1:0] w_re,
    input  logic signed [W-1:0] w_im,
    output logic                out_valid,
    output logic signed [W-1:0] top_re,
    output logic signed [W-1:0] top_im,
    output logic signed [W-1:0] bot_re,
    output logic signed [W-1:0] bot_im
);
    localparam int PW = W + 1;   // rounded product width
    localparam int VW = W + 2;   // combined product term width

    bfly_state_e state_q, state_d;

    logic accept;

    // captured operands
    logic signed [W-1:0] ur_q, ui_q, tr_q, ti_q, wr_q, wi_q;
    logic                unity_q, scale_q;

    // shared multipliers
    logic signed [W-1:0]  mul_a [NUM_MULT];
    logic signed [W-1:0]  mul_b [NUM_MULT];
    logic signed [PW-1:0] mul_y [NUM_MULT];
    logic signed [PW-1:0] part_q [NUM_MULT];

    // lane operands and results
    logic signed [W-1:0]  lane_u   [2];
    logic signed [VW-1:0] lane_v   [2];
    logic signed [W-1:0]  lane_sum [2];
    logic signed [W-1:0]  lane_dif [2];

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ST_SECOND;  // ACCEPT
            ST_SECOND: state_d = ST_IDLE;                  // FINISH
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- multiplier operand steering ----------------
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                mul_a[0] = t_re;  mul_b[0] = w_re;
                mul_a[1] = t_im;  mul_b[1] = w_im;
            end
            ST_SECOND: begin
                mul_a[0] = tr_q;  mul_b[0] = wi_q;
                mul_a[1] = ti_q;  mul_b[1] = wr_q;
            end
            default: begin
                mul_a[0] = '0;    mul_b[0] = '0;
                mul_a[1] = '0;    mul_b[1] = '0;
            end
        endcase
    end

    for (genvar m = 0; m < NUM_MULT; m++) begin : g_mult
        q15_rmul #(.W(W)) u_mul (
            .a (mul_a[m]),
            .b (mul_b[m]),
            .y (mul_y[m])
        );
    end

    // ---------------- operand capture on ACCEPT ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ur_q    <= '0;  ui_q <= '0;
            tr_q    <= '0;  ti_q <= '0;
            wr_q    <= '0;  wi_q <= '0;
            unity_q <= 1'b0;
            scale_q <= 1'b0;
            for (int m = 0; m < NUM_MULT; m++) part_q[m] <= '0;
        end else if (accept) begin
            ur_q    <= u_re;  ui_q <= u_im;
            tr_q    <= t_re;  ti_q <= t_im;
            wr_q    <= w_re;  wi_q <= w_im;
            unity_q <= in_unity;
            scale_q <= in_scale;
            for (int m = 0; m < NUM_MULT; m++) part_q[m] <= mul_y[m];
        end
    end

    // ---------------- product term assembly ----------------
    always_comb begin
        lane_u[0] = ur_q;
        lane_u[1] = ui_q;
        if (unity_q) begin
            lane_v[0] = {{2{tr_q[W-1]}}, tr_q};
            lane_v[1] = {{2{ti_q[W-1]}}, ti_q};
        end else begin
            lane_v[0] = {part_q[0][PW-1], part_q[0]} - {part_q[1][PW-1], part_q[1]};
            lane_v[1] = {mul_y[0][PW-1], mul_y[0]} + {mul_y[1][PW-1], mul_y[1]};
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_lane
        bfly_lane #(.W(W)) u_lane (
            .u     (lane_u[c]),
            .v     (lane_v[c]),
            .scale (scale_q),
            .sum   (lane_sum[c]),
            .dif   (lane_dif[c])
        );
    end

    // ---------------- outputs, loaded on FINISH ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            top_re    <= '0;
            top_im    <= '0;
            bot_re    <= '0;
            bot_im    <= '0;
        end else begin
            out_valid <= (state_q == ST_SECOND);
            if (state_q == ST_SECOND) begin
                top_re <= lane_sum[0];
                top_im <= lane_sum[1];
                bot_re <= lane_dif[0];
                bot_im <= lane_dif[1];
            end
        end
    end
endmodule

// File: rtl/bfly_checker.sv
module bfly_checker #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                in_unity,
    input logic                in_scale,
    input logic signed [W-1:0] u_re,
    input logic signed [W-1:0] u_im,
    input logic signed [W-1:0] t_re,
    input logic signed [W-1:0] t_im,
    input logic signed [W-1:0] w_re,
    input logic signed [W-1:0] w_im,
    input logic                out_valid,
    input logic signed [W-1:0] top_re,
    input logic signed [W-1:0] top_im,
    input logic signed [W-1:0] bot_re,
    input logic signed [W-1:0] bot_im
);
    localparam int XW = W + 3;

    function automatic logic signed [W-1:0] clip(input logic signed [XW-1:0] x);
        if (x > XW'((1 <<< (W - 1)) - 1))
            return W'((1 <<< (W - 1)) - 1);
        else if (x < -(XW'(1) <<< (W - 1)))
            return W'(1) <<< (W - 1);
        else
            return x[W-1:0];
    endfunction

    logic signed [W-1:0] byp_d1, byp_d2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_d1 <= '0;
            byp_d2 <= '0;
        end else begin
            byp_d1 <= clip({{3{u_re[W-1]}}, u_re} + {{3{t_re[W-1]}}, t_re});
            byp_d2 <= byp_d1;
        end
    end

    assert_pace_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 out_valid);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && in_ready && in_unity && !in_scale, 2))
            |-> (top_re == byp_d2));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(top_re) && $stable(top_im) &&
                        $stable(bot_re) && $stable(bot_im)));
endmodule

bind q15_butterfly bfly_checker #(.W(W)) u_chk (.*);

// File: tb/sim_q15_butterfly.sv
`timescale 1ns/1ps
module sim_q15_butterfly;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_unity = 1'b0, in_scale = 1'b0;
    logic in_ready, out_valid;
    logic signed [W-1:0] u_re = '0, u_im = '0, t_re = '0, t_im = '0, w_re = '0, w_im = '0;
    logic signed [W-1:0] top_re, top_im, bot_re, bot_im;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit ready_m = 1;
    bit expv = 0;
    int pend [4];
    int held [4];
    string tag = "R4";

    always #5 clk = ~clk;

    q15_butterfly #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_unity(in_unity), .in_scale(in_scale),
        .u_re(u_re), .u_im(u_im), .t_re(t_re), .t_im(t_im), .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid), .top_re(top_re), .top_im(top_im),
        .bot_re(bot_re), .bot_im(bot_im)
    );

    function automatic int rnd(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        return int'((p + 64'sd16384) >>> 15);
    endfunction

    function automatic int fin(int s, bit sc);
        int h;
        h = sc ? ((s + 1) >>> 1) : s;
        if (h > 32767) return 32767;
        if (h < -32768) return -32768;
        return h;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit acc;
        int pr, pi;
        @(negedge clk);
        check("R3", "out_valid", int'(out_valid), int'(expv));
        if (expv) begin
            check(tag, "top_re", int'(top_re), pend[0]);
            check(tag, "top_im", int'(top_im), pend[1]);
            check(tag, "bot_re", int'(bot_re), pend[2]);
            check(tag, "bot_im", int'(bot_im), pend[3]);
            held = pend;
        end else begin
            check("R9", "top_re hold", int'(top_re), held[0]);
            check("R9", "top_im hold", int'(top_im), held[1]);
            check("R9", "bot_re hold", int'(bot_re), held[2]);
            check("R9", "bot_im hold", int'(bot_im), held[3]);
        end
        acc = in_valid && ready_m;
        expv = acc;
        if (acc) begin
            if (in_unity) begin
                pr = int'(t_re);
                pi = int'(t_im);
            end else begin
                pr = rnd(int'(t_re), int'(w_re)) - rnd(int'(t_im), int'(w_im));
                pi = rnd(int'(t_re), int'(w_im)) + rnd(int'(t_im), int'(w_re));
            end
            pend[0] = fin(int'(u_re) + pr, in_scale);
            pend[1] = fin(int'(u_im) + pi, in_scale);
            pend[2] = fin(int'(u_re) - pr, in_scale);
            pend[3] = fin(int'(u_im) - pi, in_scale);
        end
        ready_m = !acc;
        check("R2", "in_ready", int'(in_ready), int'(ready_m));
    endtask

    task automatic offer(int ur, int ui, int tr, int ti, int wr, int wi, bit un, bit sc);
        u_re = W'(ur); u_im = W'(ui);
        t_re = W'(tr); t_im = W'(ti);
        w_re = W'(wr); w_im = W'(wi);
        in_unity = un; in_scale = sc;
        in_valid = 1'b1;
        step();
        in_valid = 1'b0;
        step();
        step();
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "in_ready in reset", int'(in_ready), 1);
        check("R1", "top_re in reset", int'(top_re), 0);
        check("R1", "bot_im in reset", int'(bot_im), 0);
        rst_n = 1'b1;
        step();
        step();

        tag = "R5";
        offer(100, 200, 1000, -2000, 32767, 0, 0, 0);
        offer(-5000, 7000, 3000, 4000, 0, 32767, 0, 0);

        tag = "R4";
        offer(0, 0, 12345, -321, 23170, -23170, 0, 0);
        offer(10, -10, -32768, -32768, -32768, 0, 0, 0);
        offer(0, 0, 1, 1, 16384, 16384, 0, 0);
        offer(0, 0, -1, 3, 16384, -16384, 0, 0);

        tag = "R6";
        offer(1000, -1000, 2222, 3333, 12345, -777, 1, 0);
        offer(-300, 400, -32768, 32767, -32768, -32768, 1, 0);

        tag = "R7";
        offer(1001, 3, 2000, -5, 32767, 0, 0, 1);
        offer(-7, 9, 2, -4, 0, 0, 1, 1);
        offer(32767, -32768, 32767, -32768, 0, 0, 1, 1);

        tag = "R8";
        offer(32767, 32767, 32767, 32767, 0, 0, 1, 0);
        offer(-32768, -32768, 32767, 32767, 0, 0, 1, 0);
        offer(32767, -32768, -32768, -32768, -32768, 0, 0, 0);

        // R2: held valid, data changing every cycle
        tag = "R2";
        in_valid = 1'b1;
        for (int i = 0; i < 12; i++) begin
            u_re = W'(i * 1000 - 6000); u_im = W'(i * 77);
            t_re = W'(i * 1500);        t_im = W'(-i * 900);
            w_re = W'(20000 - i * 3000); w_im = W'(i * 2500);
            in_unity = 1'b0; in_scale = i[0];
            step();
        end
        in_valid = 1'b0;
        repeat (3) step();

        // R4: random operands and random offers
        tag = "R4";
        for (int i = 0; i < 400; i++) begin
            u_re = W'($urandom); u_im = W'($urandom);
            t_re = W'($urandom); t_im = W'($urandom);
            w_re = W'($urandom); w_im = W'($urandom);
            in_unity = ($urandom % 8) == 0;
            in_scale = $urandom % 2;
            in_valid = ($urandom % 4) != 0;
            step();
        end
        in_valid = 1'b0;
        repeat (4) step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule